// File: doc/BRIEF.md
# Buck Converter Fault and Start-Up Sequencer

This block is the digital sequencer of a voltage-mode synchronous buck controller. It takes the outputs of the analog comparators: supply good, over-current, under-voltage, over-voltage and an external shutdown request. From these it decides whether the converter switches, whether the low-side switch must be forced on, and whether both gate drivers should float. It also produces the soft-start reference code that the error loop uses in place of the fixed reference until that code reaches its target.

Start-up waits for supply good. It then ramps the reference code from zero at a fixed pace, so the soft-start interval is the same whatever the input and output voltages are. An over-current fault restarts the converter through soft-start, and the fourth such event latches both gates floating. Under-voltage in regulation turns the converter off for a fixed hiccup delay and then retries, with no limit on the number of retries. Under-voltage is masked while soft-start runs. Over-voltage holds the low side on for as long as the flag stays high. All intervals are parameters counted in clock cycles.

Top module: `buck_seq`

## Requirements
- R1: While reset is high, and whenever synchronized supply good is low, the block rests in its idle-off state. In that state conv_en_o=0, gate_float_o=1, ss_ref_o=0 and stat_ocnt_o=0. Losing supply good from any state returns the block there.
- R2: Every comparator input passes through a two-flop synchronizer. A change on an input becomes visible on the outputs after exactly three rising clock edges.
- R3: Soft-start begins with ss_ref_o=0. The code rises by one every STEP_CYCLES cycles, and stat_soft_o stays high for exactly REF_TARGET*STEP_CYCLES cycles. The block then enters regulation with ss_ref_o=REF_TARGET and stat_soft_o=0. conv_en_o is high throughout soft-start and regulation.
- R4: A rising edge of the over-current flag during soft-start or regulation does three things. It adds one to stat_ocnt_o, drops conv_en_o for one cycle, and restarts soft-start from code 0. A flag held high counts only once.
- R5: The event that brings the count to OC_LIMIT (4) latches the block. The outputs become conv_en_o=0, gate_float_o=1 and stat_latched_o=1, and they stay that way until shutdown or loss of supply good.
- R6: Under-voltage during regulation switches the converter off without floating the gates. stat_hiccup_o is then high for exactly HICCUP_CYCLES cycles, and a new soft-start follows. The retries have no limit and leave the over-current count unchanged.
- R7: Under-voltage is ignored during soft-start: the ramp continues undisturbed into regulation.
- R8: While the over-voltage flag is high and the converter is enabled, low_force_o=1. It returns to 0 when the flag clears. It is 0 whenever the converter is off.
- R9: External shutdown floats both gates, clears stat_ocnt_o and exits the latched state. Releasing it starts a fresh soft-start from code 0.
- R10: Shutdown and loss of supply good override every other fault. When over-current and under-voltage arrive in the same cycle, over-current wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Supply-good comparator flag (asynchronous) |
| oc_i | input | 1 | Over-current comparator flag (asynchronous) |
| uv_i | input | 1 | Under-voltage comparator flag (asynchronous) |
| ov_i | input | 1 | Over-voltage comparator flag (asynchronous) |
| shdn_i | input | 1 | External shutdown request (asynchronous) |
| conv_en_o | output | 1 | Converter switching enable |
| low_force_o | output | 1 | Hold the low-side switch on |
| gate_float_o | output | 1 | Float both gate drivers |
| ss_ref_o | output | REF_W | Soft-start reference code |
| stat_soft_o | output | 1 | Soft-start in progress |
| stat_hiccup_o | output | 1 | Under-voltage hiccup delay running |
| stat_latched_o | output | 1 | Over-current latch-off |
| stat_ocnt_o | output | $clog2(OC_LIMIT+1) | Over-current event count |

## Verification
The ramp is swept code by code on every soft-start with a small configuration. The same sweep is repeated after power-up, after each over-current retry, after each hiccup and after each shutdown release, so a restart that does not return to code zero or that changes the pacing is caught. Over-current is tried as a held level, as a pulse during regulation and as a pulse during soft-start. These patterns separate edge counting from level counting and show that the latch takes the fourth event wherever it occurs. Under-voltage is raised during regulation to test the hiccup length, and during soft-start to test the mask. Coincident pairs of faults (over-current with under-voltage, shutdown with over-current, over-voltage with under-voltage) expose the priority order. Exact three-edge latency checks pin down the synchronizer depth.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [2:0] {
        ST_POR    = 3'd0,
        ST_SHDN   = 3'd1,
        ST_SOFT   = 3'd2,
        ST_RUN    = 3'd3,
        ST_OFF    = 3'd4,
        ST_HICCUP = 3'd5,
        ST_LATCH  = 3'd6
    } seq_state_e;

    typedef struct packed {
        logic supply;
        logic oc;
        logic uv;
        logic ov;
        logic shdn;
    } flags_t;

    localparam int FLAG_N = $bits(flags_t);

    function automatic logic st_active(seq_state_e s);
        return (s == ST_SOFT) || (s == ST_RUN);
    endfunction

    function automatic logic st_float(seq_state_e s);
        return (s == ST_POR) || (s == ST_SHDN) || (s == ST_LATCH);
    endfunction

    function automatic int cnt_width(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bcs_sync.sv
module bcs_sync #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d_i[i];
                s2 <= s1;
            end
        end
        assign q_o[i] = s2;
    end
endmodule

// File: rtl/bcs_ramp.sv
module bcs_ramp #(
    parameter int REF_W       = 8,
    parameter int REF_TARGET  = 200,
    parameter int STEP_CYCLES = 2188
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    output logic [REF_W-1:0] code_o,
    output logic             last_o
);
    localparam int DIV_W = bcs_pkg::cnt_width(STEP_CYCLES);
    localparam logic [DIV_W-1:0] DIV_END  = DIV_W'(STEP_CYCLES - 1);
    localparam logic [REF_W-1:0] CODE_TOP = REF_W'(REF_TARGET);
    localparam logic [REF_W-1:0] CODE_PRE = REF_W'(REF_TARGET - 1);

    logic [DIV_W-1:0] div_q;
    logic [REF_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            div_q  <= '0;
            code_q <= '0;
        end else if (run && (code_q != CODE_TOP)) begin
            if (div_q == DIV_END) begin
                div_q  <= '0;
                code_q <= code_q + 1'b1;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign code_o = code_q;
    assign last_o = run && (code_q == CODE_PRE) && (div_q == DIV_END);

    // R3: the code never jumps by more than one step while the ramp runs
    p_ramp_step_r3: assert property (@(posedge clk) disable iff (rst)
        (run && !clear) |=> ((code_q == $past(code_q)) ||
                             (code_q == REF_W'($past(code_q) + 1'b1))));

    // R3: the code never exceeds its target
    p_ramp_cap_r3: assert property (@(posedge clk) disable iff (rst)
        code_q <= CODE_TOP);
endmodule

// File: rtl/bcs_occnt.sv
module bcs_occnt #(
    parameter int OC_LIMIT = 4,
    localparam int CW = $clog2(OC_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          inc,
    output logic [CW-1:0] count_o
);
    localparam logic [CW-1:0] CNT_MAX = CW'(OC_LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (inc && (cnt_q != CNT_MAX))
            cnt_q <= cnt_q + 1'b1;
    end

    assign count_o = cnt_q;

    // R5: the count saturates at the latch limit
    p_cnt_cap_r5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_MAX);

    // R9: a clear request empties the count on the next edge
    p_cnt_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0));
endmodule

// File: rtl/bcs_fsm.sv
module bcs_fsm
    import bcs_pkg::*;
#(
    parameter int HICCUP_CYCLES = 500000,
    parameter int OC_LIMIT      = 4,
    localparam int CW = $clog2(OC_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          supply_s,
    input  logic          shdn_s,
    input  logic          uv_s,
    input  logic          oc_evt,
    input  logic          ramp_last,
    input  logic [CW-1:0] oc_count,
    output seq_state_e    state_o
);
    localparam int HW = cnt_width(HICCUP_CYCLES);
    localparam logic [HW-1:0] HC_END  = HW'(HICCUP_CYCLES - 1);
    localparam logic [CW-1:0] OC_LAST = CW'(OC_LIMIT - 1);

    seq_state_e st_q, st_d;
    logic [HW-1:0] hc_q;
    logic          oc_final;

    assign oc_final = (oc_count == OC_LAST);

    always_comb begin
        st_d = st_q;
        if (!supply_s) begin
            st_d = ST_POR;
        end else if (shdn_s) begin
            st_d = ST_SHDN;
        end else begin
            unique case (st_q)
                ST_POR, ST_SHDN: st_d = ST_SOFT;
                ST_SOFT: begin
                    if (oc_evt)         st_d = oc_final ? ST_LATCH : ST_OFF;
                    else if (ramp_last) st_d = ST_RUN;
                end
                ST_RUN: begin
                    if (oc_evt)    st_d = oc_final ? ST_LATCH : ST_OFF;
                    else if (uv_s) st_d = ST_HICCUP;
                end
                ST_OFF:    st_d = ST_SOFT;
                ST_HICCUP: if (hc_q == HC_END) st_d = ST_SOFT;
                ST_LATCH:  st_d = ST_LATCH;
                default:   st_d = ST_POR;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_POR;
            hc_q <= '0;
        end else begin
            st_q <= st_d;
            hc_q <= (st_q == ST_HICCUP) ? hc_q + 1'b1 : '0;
        end
    end

    assign state_o = st_q;

    // R1: loss of supply good sends the sequencer back to idle-off
    p_por_return_r1: assert property (@(posedge clk) disable iff (rst)
        !supply_s |=> (st_q == ST_POR));

    // R9: shutdown with supply present always lands in the shutdown state
    p_shdn_enter_r9: assert property (@(posedge clk) disable iff (rst)
        (supply_s && shdn_s) |=> (st_q == ST_SHDN));

    // R7: under-voltage alone cannot leave soft-start
    p_uv_masked_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SOFT && supply_s && !shdn_s && !oc_evt && uv_s)
            |=> (st_q inside {ST_SOFT, ST_RUN}));

    // R10: over-current beats under-voltage in regulation
    p_oc_first_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && supply_s && !shdn_s && oc_evt)
            |=> (st_q inside {ST_OFF, ST_LATCH}));

    // R5: the latch is left only through shutdown or supply loss
    p_latch_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LATCH && supply_s && !shdn_s) |=> (st_q == ST_LATCH));

    // R6: a hiccup ends only in a new soft-start
    p_hiccup_exit_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HICCUP && supply_s && !shdn_s)
            |=> (st_q inside {ST_HICCUP, ST_SOFT}));
endmodule

// File: rtl/buck_seq.sv
module buck_seq
    import bcs_pkg::*;
#(
    parameter int REF_W         = 8,
    parameter int REF_TARGET    = 200,
    parameter int STEP_CYCLES   = 2188,
    parameter int HICCUP_CYCLES = 500000,
    parameter int OC_LIMIT      = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          supply_ok_i,
    input  logic                          oc_i,
    input  logic                          uv_i,
    input  logic                          ov_i,
    input  logic                          shdn_i,
    output logic                          conv_en_o,
    output logic                          low_force_o,
    output logic                          gate_float_o,
    output logic [REF_W-1:0]              ss_ref_o,
    output logic                          stat_soft_o,
    output logic                          stat_hiccup_o,
    output logic                          stat_latched_o,
    output logic [$clog2(OC_LIMIT+1)-1:0] stat_ocnt_o
);
    localparam int CW = $clog2(OC_LIMIT + 1);

    flags_t            raw, fs;
    logic [FLAG_N-1:0] fs_vec;
    logic              oc_d, ov_d, oc_evt, oc_inc, cnt_clr;
    logic              ramp_last, ramp_clr, ramp_run;
    logic [REF_W-1:0]  ramp_code;
    logic [CW-1:0]     oc_count;
    seq_state_e        st;

    assign raw = '{supply: supply_ok_i, oc: oc_i, uv: uv_i, ov: ov_i, shdn: shdn_i};

    bcs_sync #(.N(FLAG_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw),
        .q_o (fs_vec)
    );
    assign fs = flags_t'(fs_vec);

    always_ff @(posedge clk) begin
        if (rst) begin
            oc_d <= 1'b0;
            ov_d <= 1'b0;
        end else begin
            oc_d <= fs.oc;
            ov_d <= fs.ov;
        end
    end

    assign oc_evt  = fs.oc && !oc_d;
    assign oc_inc  = oc_evt && st_active(st) && fs.supply && !fs.shdn;
    assign cnt_clr = !fs.supply || fs.shdn;

    bcs_occnt #(.OC_LIMIT(OC_LIMIT)) u_occnt (
        .clk     (clk),
        .rst     (rst),
        .clear   (cnt_clr),
        .inc     (oc_inc),
        .count_o (oc_count)
    );

    assign ramp_clr = !st_active(st);
    assign ramp_run = (st == ST_SOFT);

    bcs_ramp #(
        .REF_W       (REF_W),
        .REF_TARGET  (REF_TARGET),
        .STEP_CYCLES (STEP_CYCLES)
    ) u_ramp (
        .clk    (clk),
        .rst    (rst),
        .clear  (ramp_clr),
        .run    (ramp_run),
        .code_o (ramp_code),
        .last_o (ramp_last)
    );

    bcs_fsm #(
        .HICCUP_CYCLES (HICCUP_CYCLES),
        .OC_LIMIT      (OC_LIMIT)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .supply_s  (fs.supply),
        .shdn_s    (fs.shdn),
        .uv_s      (fs.uv),
        .oc_evt    (oc_evt),
        .ramp_last (ramp_last),
        .oc_count  (oc_count),
        .state_o   (st)
    );

    assign conv_en_o      = st_active(st);
    assign low_force_o    = st_active(st) && ov_d;
    assign gate_float_o   = st_float(st);
    assign ss_ref_o       = st_active(st) ? ramp_code : '0;
    assign stat_soft_o    = (st == ST_SOFT);
    assign stat_hiccup_o  = (st == ST_HICCUP);
    assign stat_latched_o = (st == ST_LATCH);
    assign stat_ocnt_o    = oc_count;

    // R8: the low side is never forced while the gates float
    p_force_not_float_r8: assert property (@(posedge clk) disable iff (rst)
        low_force_o |-> !gate_float_o);

    // R4: a fresh over-current edge in soft-start or regulation raises the count or latches
    p_oc_counts_r4: assert property (@(posedge clk) disable iff (rst)
        (oc_inc && oc_count < CW'(OC_LIMIT)) |=> (oc_count == CW'($past(oc_count) + 1'b1)));
endmodule

// File: tb/buck_seq_tb.sv
module buck_seq_tb;
    localparam int RW = 4;
    localparam int RT = 6;
    localparam int SC = 3;
    localparam int HC = 10;
    localparam int OL = 4;
    localparam int CW = $clog2(OL + 1);

    logic clk = 1'b0;
    logic rst, sup, oc, uv, ov, shdn;
    logic conv_en, low_force, gate_float, stat_soft, stat_hiccup, stat_latched;
    logic [RW-1:0] ss_ref;
    logic [CW-1:0] stat_ocnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    buck_seq #(
        .REF_W(RW), .REF_TARGET(RT), .STEP_CYCLES(SC),
        .HICCUP_CYCLES(HC), .OC_LIMIT(OL)
    ) u_dut (
        .clk(clk), .rst(rst), .supply_ok_i(sup), .oc_i(oc), .uv_i(uv),
        .ov_i(ov), .shdn_i(shdn), .conv_en_o(conv_en), .low_force_o(low_force),
        .gate_float_o(gate_float), .ss_ref_o(ss_ref), .stat_soft_o(stat_soft),
        .stat_hiccup_o(stat_hiccup), .stat_latched_o(stat_latched),
        .stat_ocnt_o(stat_ocnt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called on the first sample with soft-start visible; returns on the first
    // sample in regulation. Optionally pulses under-voltage (R7).
    task automatic ramp_check(input int uv_on, input int uv_off);
        for (int k = 0; k <= RT * SC; k++) begin
            if (k == uv_on)  uv = 1'b1;
            if (k == uv_off) uv = 1'b0;
            if (k < RT * SC) begin
                chk("R3 ramp code", ss_ref, k / SC);
                chk("R3 soft flag", stat_soft, 1);
            end else begin
                chk("R3 final code", ss_ref, RT);
                chk("R3 soft done", stat_soft, 0);
                chk("R7 no hiccup after masked uv", stat_hiccup, 0);
            end
            chk("R3 enable", conv_en, 1);
            if (k < RT * SC) cyc(1);
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sup = 1'b0; oc = 1'b0; uv = 1'b0; ov = 1'b0; shdn = 1'b0;
        cyc(4);
        rst = 1'b0;
        cyc(2);
        // R1: idle-off state
        chk("R1 enable", conv_en, 0);
        chk("R1 float", gate_float, 1);
        chk("R1 ref", ss_ref, 0);
        chk("R1 count", stat_ocnt, 0);

        // R2: three-edge latency on supply good
        sup = 1'b1;
        cyc(2);
        chk("R2 not yet", conv_en, 0);
        cyc(1);
        chk("R2 arrived", conv_en, 1);
        chk("R2 float off", gate_float, 0);
        ramp_check(-1, -1);
        cyc(5);
        chk("R3 holds regulation", ss_ref, RT);

        // R8: over-voltage forcing
        ov = 1'b1;
        cyc(2);
        chk("R2 ov latency", low_force, 0);
        cyc(1);
        chk("R8 force on", low_force, 1);
        chk("R8 still enabled", conv_en, 1);
        ov = 1'b0;
        cyc(3);
        chk("R8 force released", low_force, 0);

        // R4: held over-current counts once and restarts
        oc = 1'b1;
        cyc(3);
        chk("R4 off cycle", conv_en, 0);
        chk("R4 not floating", gate_float, 0);
        chk("R4 count one", stat_ocnt, 1);
        cyc(1);
        chk("R4 restart soft", stat_soft, 1);
        ramp_check(-1, -1);
        chk("R4 held level counts once", stat_ocnt, 1);
        oc = 1'b0;
        cyc(3);

        // R6: hiccup from under-voltage, then masked uv in soft-start (R7)
        uv = 1'b1;
        cyc(3);
        chk("R6 hiccup", stat_hiccup, 1);
        chk("R6 off", conv_en, 0);
        chk("R6 not floating", gate_float, 0);
        chk("R6 count kept", stat_ocnt, 1);
        uv = 1'b0;
        cyc(HC - 1);
        chk("R6 hiccup last cycle", stat_hiccup, 1);
        cyc(1);
        chk("R6 soft after hiccup", stat_soft, 1);
        chk("R6 ref zero", ss_ref, 0);
        ramp_check(2, 8);

        // R6 again, with over-voltage while off (R8)
        uv = 1'b1; ov = 1'b1;
        cyc(3);
        chk("R6 second hiccup", stat_hiccup, 1);
        chk("R8 no force while off", low_force, 0);
        uv = 1'b0; ov = 1'b0;
        cyc(HC);
        chk("R6 second retry", stat_soft, 1);
        ramp_check(-1, -1);
        chk("R6 count unchanged", stat_ocnt, 1);

        // R10: over-current beats under-voltage
        oc = 1'b1; uv = 1'b1;
        cyc(3);
        chk("R10 no hiccup", stat_hiccup, 0);
        chk("R10 off", conv_en, 0);
        chk("R10 count two", stat_ocnt, 2);
        uv = 1'b0;
        cyc(1);
        ramp_check(-1, -1);
        oc = 1'b0;
        cyc(3);

        // R4 and R5: third event in regulation, fourth during soft-start
        oc = 1'b1;
        cyc(3);
        chk("R4 count three", stat_ocnt, 3);
        cyc(1);
        chk("R4 soft again", stat_soft, 1);
        oc = 1'b0;
        cyc(4);
        oc = 1'b1;
        cyc(3);
        chk("R5 latched", stat_latched, 1);
        chk("R5 float", gate_float, 1);
        chk("R5 off", conv_en, 0);
        chk("R5 count four", stat_ocnt, 4);
        oc = 1'b0;
        cyc(20);
        chk("R5 stays latched", stat_latched, 1);
        chk("R5 stays off", conv_en, 0);

        // R9: shutdown leaves the latch and clears the count
        shdn = 1'b1;
        cyc(3);
        chk("R9 unlatched", stat_latched, 0);
        chk("R9 float", gate_float, 1);
        chk("R9 count cleared", stat_ocnt, 0);
        shdn = 1'b0;
        cyc(3);
        chk("R9 fresh soft", stat_soft, 1);
        chk("R9 ref zero", ss_ref, 0);
        ramp_check(-1, -1);

        // R10: shutdown beats over-current
        oc = 1'b1; shdn = 1'b1;
        cyc(3);
        chk("R10 shutdown wins", gate_float, 1);
        chk("R10 no count", stat_ocnt, 0);
        oc = 1'b0; shdn = 1'b0;
        cyc(3);
        ramp_check(-1, -1);

        // R1: supply loss from soft-start clears everything
        oc = 1'b1;
        cyc(3);
        oc = 1'b0;
        cyc(1);
        chk("R4 count before loss", stat_ocnt, 1);
        sup = 1'b0;
        cyc(3);
        chk("R1 loss float", gate_float, 1);
        chk("R1 loss off", conv_en, 0);
        chk("R1 loss ref", ss_ref, 0);
        chk("R1 loss count", stat_ocnt, 0);
        sup = 1'b1;
        cyc(3);
        ramp_check(-1, -1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule